// File: doc/BRIEF.md
# Lockable Translation Lookaside Buffer

This block is a small, fully associative address-translation cache for a device-side MMU. It holds `N` entries. Each entry pairs a match part with a translation part. The match part holds a virtual tag, a two-bit page-size code, a valid flag and a keep flag. The translation part holds a physical base. A lookup port takes a 32-bit device address. In the same cycle it returns a hit flag, the translated physical address and the page size of the entry that matched.

Entries are installed through a register-style command port. The block keeps a lock pair of two fields. The floor field marks how many of the lowest slots are pinned. The pointer field names the slot that the next load writes and that read-back shows. Ordinary loads advance the pointer round-robin. When the pointer passes the last slot it wraps to the floor, not to zero, so pinned entries are never replaced. A load with the keep flag set goes to the floor slot and raises the floor by one. Software can also write the lock pair directly, drop every entry that covers one address, or clear the whole buffer.

Top module: `lockable_tlb`

## Requirements
- R1: After reset, floor and pointer are 0, the refusal flag is 0, no lookup hits, and read-back of slot 0 shows valid bit 0.
- R2: A load command (op code 2) writes the staged words into the slot the pointer names. Read-back of the slot under the pointer returns them. The match word has tag in bits 31:12, valid in bit 3, keep in bit 2 and size in bits 1:0 (0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB). The translation word holds the physical base in bits 31:12.
- R3: After an ordinary load (keep bit 0), the pointer moves up by one. If it would reach `N`, it takes the floor value instead.
- R4: A load with the keep bit set writes the slot at the floor, raises the floor by one, and leaves the pointer at the new floor.
- R5: A keep load while the floor equals `N` is refused, and so is an ordinary load while the pointer equals `N`. A refused load changes no entry and no lock field, and the refusal flag is high in the cycle after it.
- R6: A lock write (op code 1) sets floor and pointer to the supplied values, each clamped to `N`. The outputs show the new values.
- R7: A lookup hits when a valid entry's tag equals the address above that entry's page offset. The result is the entry's physical base above the offset, joined with the address bits inside the offset, plus the entry's size code.
- R8: When several valid entries match, the lookup returns the lowest-numbered one.
- R9: An entry loaded with valid bit 0 never matches, and its read-back shows valid bit 0.
- R10: A flush by address (op code 3) invalidates every valid entry whose page contains the address. It leaves other entries and both lock fields unchanged.
- R11: A global flush (op code 4) invalidates all entries and sets floor and pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_op | input | 3 | Command: 0 idle, 1 lock write, 2 load, 3 flush address, 4 flush all |
| ctl_cam | input | 32 | Staged match word for a load |
| ctl_ram | input | 32 | Staged translation word for a load |
| ctl_addr | input | 32 | Address for flush by address |
| ctl_floor | input | $clog2(N+1) | Floor value for a lock write |
| ctl_ptr | input | $clog2(N+1) | Pointer value for a lock write |
| lock_floor | output | $clog2(N+1) | Current floor |
| lock_ptr | output | $clog2(N+1) | Current pointer |
| ld_refused | output | 1 | High for one cycle after a refused load |
| rd_cam | output | 32 | Match word of the slot under the pointer (0 when pointer is N) |
| rd_ram | output | 32 | Translation word of the slot under the pointer |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated address |
| lk_size | output | 2 | Page-size code of the matching entry |

## Verification
A wrong floor or pointer shows first as the wrong lock values one cycle after a load. It then shows as a wrong slot in read-back, and as a pinned translation that vanishes from lookups once ordinary loads wrap. A wrong valid bit or page mask in any entry changes `lk_hit` or `lk_pa` in the same cycle the lookup address is applied. The directed cases therefore read the lock pair after every load and probe addresses just inside and just outside each page size.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int ADDR_W = 32;
    localparam int PG_SH  = 12;
    localparam int TAG_W  = ADDR_W - PG_SH;

    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_SETLOCK   = 3'd1,
        OP_LOAD      = 3'd2,
        OP_FLUSH_VA  = 3'd3,
        OP_FLUSH_ALL = 3'd4
    } tlb_op_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             vld;
        logic             keep;
        logic [1:0]       psz;
        logic [TAG_W-1:0] pbase;
    } tlb_ent_t;

    // Mask of the in-page offset bits for a size code
    function automatic logic [ADDR_W-1:0] off_mask(input logic [1:0] code);
        logic [ADDR_W-1:0] m;
        case (code)
            2'd0:    m = 32'h0000_0FFF;
            2'd1:    m = 32'h0000_FFFF;
            2'd2:    m = 32'h000F_FFFF;
            default: m = 32'h00FF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  tlb_ent_t          ent,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [ADDR_W-1:0] page_mask;
    logic [ADDR_W-1:0] start_va;

    always_comb begin
        page_mask = ~off_mask(ent.psz);
        start_va  = {ent.tag, {PG_SH{1'b0}}};
        hit       = ent.vld && ((addr & page_mask) == (start_va & page_mask));
    end
endmodule

// File: rtl/tlb_first_pick.sv
module tlb_first_pick #(
    parameter int N = 8,
    localparam int IXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   req,
    output logic           found,
    output logic [IXW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IXW'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_lock_ctrl.sv
module tlb_lock_ctrl
    import tlb_pkg::*;
#(
    parameter int N = 8,
    localparam int IW  = $clog2(N + 1),
    localparam int IXW = (N > 1) ? $clog2(N) : 1
) (
    input  tlb_op_e        op,
    input  logic           keep_in,
    input  logic [IW-1:0]  floor_in,
    input  logic [IW-1:0]  ptr_in,
    input  logic [IW-1:0]  floor_q,
    input  logic [IW-1:0]  ptr_q,
    output logic [IW-1:0]  floor_d,
    output logic [IW-1:0]  ptr_d,
    output logic           wr_en,
    output logic [IXW-1:0] wr_slot,
    output logic           refused
);
    localparam logic [IW-1:0] LIM = IW'(N);

    logic [IW-1:0] step;

    always_comb begin
        floor_d = floor_q;
        ptr_d   = ptr_q;
        wr_en   = 1'b0;
        wr_slot = ptr_q[IXW-1:0];
        refused = 1'b0;
        step    = '0;
        case (op)
            OP_SETLOCK: begin
                floor_d = (floor_in > LIM) ? LIM : floor_in;
                ptr_d   = (ptr_in > LIM) ? LIM : ptr_in;
            end
            OP_LOAD: begin
                if (keep_in) begin
                    if (floor_q >= LIM) begin
                        refused = 1'b1;
                    end else begin
                        wr_en   = 1'b1;
                        wr_slot = floor_q[IXW-1:0];
                        floor_d = floor_q + IW'(1);
                        step    = floor_q + IW'(1);
                        ptr_d   = (step == LIM) ? floor_d : step;
                    end
                end else begin
                    if (ptr_q >= LIM) begin
                        refused = 1'b1;
                    end else begin
                        wr_en   = 1'b1;
                        wr_slot = ptr_q[IXW-1:0];
                        step    = ptr_q + IW'(1);
                        ptr_d   = (step == LIM) ? floor_q : step;
                    end
                end
            end
            OP_FLUSH_ALL: begin
                floor_d = '0;
                ptr_d   = '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lockable_tlb.sv
module lockable_tlb
    import tlb_pkg::*;
#(
    parameter int N = 8,
    localparam int IW  = $clog2(N + 1),
    localparam int IXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    ctl_op,
    input  logic [31:0]   ctl_cam,
    input  logic [31:0]   ctl_ram,
    input  logic [31:0]   ctl_addr,
    input  logic [IW-1:0] ctl_floor,
    input  logic [IW-1:0] ctl_ptr,
    output logic [IW-1:0] lock_floor,
    output logic [IW-1:0] lock_ptr,
    output logic          ld_refused,
    output logic [31:0]   rd_cam,
    output logic [31:0]   rd_ram,
    input  logic [31:0]   lk_addr,
    output logic          lk_hit,
    output logic [31:0]   lk_pa,
    output logic [1:0]    lk_size
);
    localparam logic [IW-1:0] LIM = IW'(N);

    typedef struct packed {
        tlb_ent_t [N-1:0] ents;
        logic [IW-1:0]    floor;
        logic [IW-1:0]    ptr;
        logic             busy;
    } tlb_state_t;

    tlb_state_t st_q, st_d;
    tlb_op_e    op;

    logic [IW-1:0]  floor_nx, ptr_nx;
    logic           wr_en, refused;
    logic [IXW-1:0] wr_slot;
    logic [N-1:0]   lk_match, fl_match;
    logic           lk_found;
    logic [IXW-1:0] lk_idx;
    tlb_ent_t       new_ent, lk_ent, rd_ent;

    assign op = tlb_op_e'(ctl_op);

    tlb_lock_ctrl #(.N(N)) i_lock (
        .op      (op),
        .keep_in (ctl_cam[2]),
        .floor_in(ctl_floor),
        .ptr_in  (ctl_ptr),
        .floor_q (st_q.floor),
        .ptr_q   (st_q.ptr),
        .floor_d (floor_nx),
        .ptr_d   (ptr_nx),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .refused (refused)
    );

    for (genvar g = 0; g < N; g++) begin : g_cmp
        tlb_match i_lk (.ent(st_q.ents[g]), .addr(lk_addr),  .hit(lk_match[g]));
        tlb_match i_fl (.ent(st_q.ents[g]), .addr(ctl_addr), .hit(fl_match[g]));
    end

    tlb_first_pick #(.N(N)) i_pick (
        .req  (lk_match),
        .found(lk_found),
        .idx  (lk_idx)
    );

    always_comb begin
        new_ent.tag   = ctl_cam[31:PG_SH];
        new_ent.vld   = ctl_cam[3];
        new_ent.keep  = ctl_cam[2];
        new_ent.psz   = ctl_cam[1:0];
        new_ent.pbase = ctl_ram[31:PG_SH];

        st_d       = st_q;
        st_d.floor = floor_nx;
        st_d.ptr   = ptr_nx;
        st_d.busy  = refused;
        if (wr_en) begin
            st_d.ents[wr_slot] = new_ent;
        end
        for (int i = 0; i < N; i++) begin
            if ((op == OP_FLUSH_VA && fl_match[i]) || op == OP_FLUSH_ALL) begin
                st_d.ents[i].vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        lk_ent  = st_q.ents[lk_idx];
        lk_hit  = lk_found;
        lk_size = lk_found ? lk_ent.psz : 2'd0;
        lk_pa   = lk_found ? (({lk_ent.pbase, {PG_SH{1'b0}}} & ~off_mask(lk_ent.psz))
                              | (lk_addr & off_mask(lk_ent.psz))) : 32'h0;

        rd_ent  = st_q.ents[st_q.ptr[IXW-1:0]];
        if (st_q.ptr < LIM) begin
            rd_cam = {rd_ent.tag, 8'h00, rd_ent.vld, rd_ent.keep, rd_ent.psz};
            rd_ram = {rd_ent.pbase, {PG_SH{1'b0}}};
        end else begin
            rd_cam = 32'h0;
            rd_ram = 32'h0;
        end
    end

    assign lock_floor = st_q.floor;
    assign lock_ptr   = st_q.ptr;
    assign ld_refused = st_q.busy;

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int N = 8,
    localparam int IW = $clog2(N + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    ctl_op,
    input logic [31:0]   ctl_cam,
    input logic [IW-1:0] lock_floor,
    input logic [IW-1:0] lock_ptr,
    input logic          ld_refused,
    input logic [31:0]   lk_addr,
    input logic          lk_hit,
    input logic [31:0]   lk_pa
);
    localparam logic [IW-1:0] LIM  = IW'(N);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    // R11
    gflush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_op == 3'd4) |-> (lock_floor == '0 && lock_ptr == '0 && !lk_hit));

    // R4
    keep_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_op == 3'd2 && ctl_cam[2] && lock_floor < LIM)
        |-> (lock_floor == $past(lock_floor) + IW'(1) && lock_ptr == lock_floor));

    // R5
    keep_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_op == 3'd2 && ctl_cam[2] && lock_floor == LIM)
        |-> (ld_refused && lock_floor == LIM && $stable(lock_ptr)));

    // R3
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_op == 3'd2 && !ctl_cam[2] && lock_ptr == LAST)
        |-> lock_ptr == $past(lock_floor));

    // R7
    page_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_pa[11:0] == lk_addr[11:0]);

    // R6
    lock_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_floor <= LIM && lock_ptr <= LIM));
endmodule

bind lockable_tlb tlb_chk #(.N(N)) i_tlb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_op    (ctl_op),
    .ctl_cam   (ctl_cam),
    .lock_floor(lock_floor),
    .lock_ptr  (lock_ptr),
    .ld_refused(ld_refused),
    .lk_addr   (lk_addr),
    .lk_hit    (lk_hit),
    .lk_pa     (lk_pa)
);

// File: tb/test_lockable_tlb.sv
`timescale 1ns/1ps
module test_lockable_tlb;
    localparam int N  = 8;
    localparam int IW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    ctl_op = 3'd0;
    logic [31:0]   ctl_cam = '0, ctl_ram = '0, ctl_addr = '0;
    logic [IW-1:0] ctl_floor = '0, ctl_ptr = '0;
    logic [IW-1:0] lock_floor, lock_ptr;
    logic          ld_refused;
    logic [31:0]   rd_cam, rd_ram;
    logic [31:0]   lk_addr = '0;
    logic          lk_hit;
    logic [31:0]   lk_pa;
    logic [1:0]    lk_size;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    lockable_tlb #(.N(N)) i_lockable_tlb (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one command at a falling edge; returns at the next falling edge
    task automatic cmd(input logic [2:0] op, input logic [31:0] cam, input logic [31:0] ram,
                       input logic [31:0] addr, input int fl, input int pt);
        ctl_op = op; ctl_cam = cam; ctl_ram = ram; ctl_addr = addr;
        ctl_floor = IW'(fl); ctl_ptr = IW'(pt);
        @(posedge clk);
        @(negedge clk);
        ctl_op = 3'd0;
    endtask

    function automatic logic [31:0] mk_cam(input logic [31:0] va, input bit v, input bit k,
                                           input logic [1:0] sz);
        return {va[31:12], 8'h00, v, k, sz};
    endfunction

    task automatic look(input string req, input logic [31:0] a, input bit hit,
                        input logic [31:0] pa, input logic [1:0] sz);
        lk_addr = a;
        #0.5;
        check(req, {31'd0, lk_hit}, {31'd0, hit});
        if (hit) begin
            check(req, lk_pa, pa);
            check(req, {30'd0, lk_size}, {30'd0, sz});
        end
    endtask

    task automatic lock_is(input string req, input int fl, input int pt);
        check(req, 32'(lock_floor), 32'(fl));
        check(req, 32'(lock_ptr), 32'(pt));
    endtask

    task automatic t_reset;
        lock_is("R1", 0, 0);
        check("R1", {31'd0, ld_refused}, 32'd0);
        check("R1", {31'd0, rd_cam[3]}, 32'd0);
        look("R1", 32'h0000_0000, 0, 0, 0);
    endtask

    task automatic t_round_robin;
        cmd(3'd4, 0, 0, 0, 0, 0);
        for (int i = 0; i < N; i++) begin
            cmd(3'd2, mk_cam(32'h4000_0000 + i * 32'h1000, 1, 0, 2'd0),
                32'h8000_0000 + i * 32'h10000, 0, 0, 0);
            lock_is("R3", 0, (i + 1 == N) ? 0 : i + 1);
        end
        cmd(3'd1, 0, 0, 0, 0, 3);
        lock_is("R6", 0, 3);
        check("R2", rd_cam, mk_cam(32'h4000_3000, 1, 0, 2'd0));
        check("R2", rd_ram, 32'h8003_0000);
        look("R7", 32'h4000_5abc, 1, 32'h8005_0abc, 2'd0);
        look("R7", 32'h4000_8000, 0, 0, 0);
        cmd(3'd1, 0, 0, 0, 12, 15);
        lock_is("R6", N, N);
        check("R6", rd_cam, 32'h0);
    endtask

    task automatic t_keep;
        cmd(3'd4, 0, 0, 0, 0, 0);
        cmd(3'd2, mk_cam(32'h1111_1000, 1, 1, 2'd0), 32'h1234_5000, 0, 0, 0);
        lock_is("R4", 1, 1);
        cmd(3'd2, mk_cam(32'h2222_2000, 1, 1, 2'd0), 32'h2345_6000, 0, 0, 0);
        lock_is("R4", 2, 2);
        for (int i = 0; i < N - 1; i++) begin
            cmd(3'd2, mk_cam(32'h3000_0000 + i * 32'h1000, 1, 0, 2'd0), 32'h7000_0000, 0, 0, 0);
            if (i == N - 3) lock_is("R3", 2, 2);
        end
        lock_is("R3", 2, 3);
        look("R4", 32'h1111_1044, 1, 32'h1234_5044, 2'd0);
        look("R4", 32'h2222_2088, 1, 32'h2345_6088, 2'd0);
        look("R3", 32'h3000_0000, 0, 0, 0);
    endtask

    task automatic t_refuse;
        cmd(3'd1, 0, 0, 0, N, N);
        cmd(3'd2, mk_cam(32'h3333_3000, 1, 1, 2'd0), 32'h4444_4000, 0, 0, 0);
        check("R5", {31'd0, ld_refused}, 32'd1);
        lock_is("R5", N, N);
        cmd(3'd0, 0, 0, 0, 0, 0);
        check("R5", {31'd0, ld_refused}, 32'd0);
        cmd(3'd2, mk_cam(32'h3333_3000, 1, 0, 2'd0), 32'h4444_4000, 0, 0, 0);
        check("R5", {31'd0, ld_refused}, 32'd1);
        lock_is("R5", N, N);
        look("R5", 32'h3333_3000, 0, 0, 0);
    endtask

    task automatic t_sizes;
        cmd(3'd4, 0, 0, 0, 0, 0);
        cmd(3'd2, mk_cam(32'h0012_0000, 1, 0, 2'd1), 32'h0A00_0000, 0, 0, 0);
        cmd(3'd2, mk_cam(32'h0300_0000, 1, 0, 2'd2), 32'h0B20_0000, 0, 0, 0);
        cmd(3'd2, mk_cam(32'h5000_0000, 1, 0, 2'd3), 32'h0C00_0000, 0, 0, 0);
        look("R7", 32'h0012_abcd, 1, 32'h0A00_abcd, 2'd1);
        look("R7", 32'h0013_0000, 0, 0, 0);
        look("R7", 32'h030F_1234, 1, 32'h0B2F_1234, 2'd2);
        look("R7", 32'h0310_0000, 0, 0, 0);
        look("R7", 32'h50AB_CDEF, 1, 32'h0CAB_CDEF, 2'd3);
        look("R7", 32'h5100_0000, 0, 0, 0);
    endtask

    task automatic t_first_and_flush;
        cmd(3'd4, 0, 0, 0, 0, 0);
        cmd(3'd2, mk_cam(32'h0770_5000, 1, 0, 2'd0), 32'h0D00_0000, 0, 0, 0);
        cmd(3'd2, mk_cam(32'h0770_0000, 1, 0, 2'd2), 32'h0E00_0000, 0, 0, 0);
        cmd(3'd2, mk_cam(32'h0900_0000, 1, 0, 2'd0), 32'h0F00_0000, 0, 0, 0);
        look("R8", 32'h0770_5123, 1, 32'h0D00_0123, 2'd0);
        look("R8", 32'h0770_6000, 1, 32'h0E00_6000, 2'd2);
        cmd(3'd3, 0, 0, 32'h0770_5800, 0, 0);
        look("R10", 32'h0770_5123, 0, 0, 0);
        look("R10", 32'h0770_6000, 0, 0, 0);
        look("R10", 32'h0900_0010, 1, 32'h0F00_0010, 2'd0);
        lock_is("R10", 0, 3);
    endtask

    task automatic t_invalid;
        cmd(3'd2, mk_cam(32'h0AAA_A000, 0, 0, 2'd0), 32'h0123_4000, 0, 0, 0);
        look("R9", 32'h0AAA_A000, 0, 0, 0);
        cmd(3'd1, 0, 0, 0, 0, 3);
        check("R9", rd_cam, mk_cam(32'h0AAA_A000, 0, 0, 2'd0));
    endtask

    task automatic t_gflush;
        cmd(3'd1, 0, 0, 0, 2, 5);
        lock_is("R6", 2, 5);
        cmd(3'd4, 0, 0, 0, 0, 0);
        lock_is("R11", 0, 0);
        look("R11", 32'h0900_0010, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_round_robin();
        t_keep();
        t_refuse();
        t_sizes();
        t_first_and_flush();
        t_invalid();
        t_gflush();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule